// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block gathers interrupt requests from eight sources (four external pins, three timer overflow strobes and one serial port) and presents the single most urgent one to a CPU as a valid flag, a source index and a fixed vector address. Each source has its own enable bit. A global enable sits above all of them. The four external pins are active low, and each can be set to edge or level sensing.

When the CPU takes the interrupt it pulses `ack`. That cycle clears the latched flag of the vectored source, if the source has one, and the block enters service. While it is in service no further vector is offered. Requests that arrive in that time are kept, and they are presented once `eoi` is pulsed. The serial request is the OR of two flags that software owns, so an acknowledge never clears it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source index k (0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial, 5 = timer 2, 6 = external 2, 7 = external 3) is presented with `irq_src` = k and `irq_vector` = 03h + 8*k.
- R2: When several enabled requests are pending, the lowest source index is presented.
- R3: `en_base[k]` enables source k for k = 0..5, and `en_ext_hi[0]` and `en_ext_hi[1]` enable sources 6 and 7. A disabled request is not presented, but a latched flag survives while its source is disabled.
- R4: While `global_en` is 0, `irq_valid` is 0.
- R5: The external pins map as `ext_pin_n` bits 0, 1, 2 and 3 to sources 0, 2, 6 and 7. `ext_edge_mode` uses the same bit order. With the mode bit at 1, a falling edge on the pin seen on consecutive clocks latches a request, and the request stays after the pin returns high.
- R6: With the mode bit at 0, the request equals the inverted pin level. Nothing is latched, so a low pulse leaves no request once the pin is high again.
- R7: A one-cycle pulse on `tmr_ovf` bit 0, 1 or 2 latches a request for source 1, 3 or 5. The request is cleared when that source is acknowledged.
- R8: `ack` while `irq_valid` is 1 clears only the latched flag of the presented source. Other pending requests remain.
- R9: After an accepted `ack`, `irq_valid` stays 0 until `eoi` is pulsed. Requests pending during service are then presented.
- R10: The serial request is `ser_rx_flag | ser_tx_flag`, and an acknowledge does not clear it.
- R11: After reset no request is latched, the block is not in service, and `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_n | input | 4 | External request pins, active low (ext 0, 1, 2, 3) |
| ext_edge_mode | input | 4 | Per-pin trigger type: 1 = edge, 0 = level |
| tmr_ovf | input | 3 | Overflow strobes of timers 0, 1, 2 |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| en_base | input | 6 | Enables for sources 0 to 5 |
| en_ext_hi | input | 2 | Enables for external 2 and 3 |
| global_en | input | 1 | Master enable |
| ack | input | 1 | CPU vectors to the presented interrupt |
| eoi | input | 1 | End of service |
| irq_valid | output | 1 | A vector is offered |
| irq_vector | output | 8 | Vector address of the offered source |
| irq_src | output | 3 | Index of the offered source |

## Verification
The main function is driven from a table of level-sensed pin and serial patterns. The table includes single sources, which pin down each vector address. It includes pairs of sources, which show that the fixed order decides between them. Other rows have sources masked by a per-source bit, by the extension bits or by the global bit, which separates correct masking from plain priority. Directed sequences then compare edge and level sensing for the same pin pulse, stack timer strobes behind an edge request to test clearing on acknowledge, and show the serial flags surviving an acknowledge while a request latched during service waits for `eoi`.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC       = 8;
  localparam int SRC_W      = $clog2(NSRC);
  localparam int VEC_W      = 8;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;
  localparam int NEXT       = 4;
  localparam int NTMR       = 3;
  localparam int SER_SRC    = 4;

  // vector address for a source index
  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
    return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
  endfunction

  // source index of external pin e
  function automatic int ext_src(input int e);
    return (e < 2) ? 2 * e : e + 4;
  endfunction

  // source index of timer t
  function automatic int tmr_src(input int t);
    return 2 * t + 1;
  endfunction

  // lowest set bit wins
  function automatic logic [SRC_W-1:0] first_set(input logic [NSRC-1:0] req);
    logic [SRC_W-1:0] idx;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) idx = SRC_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/irq_ext_trigger.sv
module irq_ext_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req,
  output logic flag_q
);
  logic pin_q;
  logic fall_hit;

  assign fall_hit = edge_mode & pin_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      pin_q <= pin_n;
      if (!edge_mode)    flag_q <= 1'b0;
      else if (fall_hit) flag_q <= 1'b1;
      else if (clr)      flag_q <= 1'b0;
    end
  end

  assign req = edge_mode ? flag_q : ~pin_n;

  // R5
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_hit |=> flag_q);

  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |-> (req == ~pin_n));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  output logic             any,
  output logic [SRC_W-1:0] idx
);
  assign any = |req;
  assign idx = first_set(req);

  // R2
  prio_low_chk: assert property (@(req) any |-> ((req & ((NSRC'(1) << idx) - NSRC'(1))) == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NEXT-1:0]      ext_pin_n,
  input  logic [NEXT-1:0]      ext_edge_mode,
  input  logic [NTMR-1:0]      tmr_ovf,
  input  logic                 ser_rx_flag,
  input  logic                 ser_tx_flag,
  input  logic [5:0]           en_base,
  input  logic [1:0]           en_ext_hi,
  input  logic                 global_en,
  input  logic                 ack,
  input  logic                 eoi,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vector,
  output logic [SRC_W-1:0]     irq_src
);
  logic [NSRC-1:0] raw_req;
  logic [NSRC-1:0] gated_req;
  logic [NSRC-1:0] clr_onehot;
  logic [NTMR-1:0] tmr_flag;
  logic [NEXT-1:0] ext_flag;
  logic            in_service;
  logic            take;
  logic            any_req;
  logic [SRC_W-1:0] win_idx;

  assign take       = ack & irq_valid;
  assign clr_onehot = take ? (NSRC'(1) << win_idx) : '0;

  // external pins
  for (genvar e = 0; e < NEXT; e++) begin : g_ext
    localparam int S = ext_src(e);
    irq_ext_trigger u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_pin_n[e]),
      .edge_mode (ext_edge_mode[e]),
      .clr       (clr_onehot[S]),
      .req       (raw_req[S]),
      .flag_q    (ext_flag[e])
    );
  end

  // timer overflow flags
  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    localparam int S = tmr_src(t);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             tmr_flag[t] <= 1'b0;
      else if (tmr_ovf[t])    tmr_flag[t] <= 1'b1;
      else if (clr_onehot[S]) tmr_flag[t] <= 1'b0;
    end
    assign raw_req[S] = tmr_flag[t];

    // R7
    tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && irq_src == SRC_W'(S) && !tmr_ovf[t]) |=> !tmr_flag[t]);
    // R7
    tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[t] |=> tmr_flag[t]);
  end

  assign raw_req[SER_SRC] = ser_rx_flag | ser_tx_flag;

  assign gated_req = raw_req & {en_ext_hi, en_base} & {NSRC{global_en}};

  irq_prio_sel u_sel (
    .req (gated_req),
    .any (any_req),
    .idx (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    in_service <= 1'b0;
    else if (take) in_service <= 1'b1;
    else if (eoi)  in_service <= 1'b0;
  end

  assign irq_valid  = any_req & ~in_service;
  assign irq_src    = win_idx;
  assign irq_vector = vec_of(win_idx);

  // R9
  svc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eoi) |=> !irq_valid);

  // R4
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !global_en |-> !irq_valid);

  // R1
  vec_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == {2'b00, irq_src, 3'b011}));

  // R8
  other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_src != SRC_W'(ext_src(1)) && ext_flag[1] && ext_edge_mode[1]) |=> ext_flag[1]);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_pin_n = 4'hF;
  logic [3:0] ext_edge_mode = 4'h0;
  logic [2:0] tmr_ovf = 3'b000;
  logic       ser_rx_flag = 1'b0;
  logic       ser_tx_flag = 1'b0;
  logic [5:0] en_base = 6'h3F;
  logic [1:0] en_ext_hi = 2'b11;
  logic       global_en = 1'b1;
  logic       ack = 1'b0;
  logic       eoi = 1'b0;
  logic       irq_valid;
  logic [7:0] irq_vector;
  logic [2:0] irq_src;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf(tmr_ovf), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .en_base(en_base), .en_ext_hi(en_ext_hi), .global_en(global_en),
    .ack(ack), .eoi(eoi), .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_src(irq_src)
  );

  // {pins[3:0], rx, tx, en[7:0], global, exp_valid, exp_vec[7:0]}
  localparam int NV = 10;
  localparam logic [23:0] TBL [NV] = '{
    {4'b1111, 2'b00, 8'hFF, 1'b1, 1'b0, 8'h00},
    {4'b0111, 2'b00, 8'hFF, 1'b1, 1'b1, 8'h3B},
    {4'b0011, 2'b00, 8'hFF, 1'b1, 1'b1, 8'h33},
    {4'b1110, 2'b10, 8'hFF, 1'b1, 1'b1, 8'h03},
    {4'b1111, 2'b01, 8'hFF, 1'b1, 1'b1, 8'h23},
    {4'b1101, 2'b10, 8'hFF, 1'b1, 1'b1, 8'h13},
    {4'b1110, 2'b10, 8'hFE, 1'b1, 1'b1, 8'h23},
    {4'b0000, 2'b11, 8'hFF, 1'b0, 1'b0, 8'h00},
    {4'b0011, 2'b10, 8'h3F, 1'b1, 1'b1, 8'h23},
    {4'b0111, 2'b00, 8'h7F, 1'b1, 1'b0, 8'h00}
  };

  // expected vector address for a source index
  function automatic logic [7:0] exp_vec(input int k);
    return 8'(8 * k + 3);
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic ev, input logic [7:0] evec);
    tests++;
    if (irq_valid !== ev || (ev && irq_vector !== evec)) begin
      fails++;
      $display("FAIL %s: valid=%0b vector=%02h expected valid=%0b vector=%02h",
               req, irq_valid, irq_vector, ev, evec);
    end
  endtask

  task automatic service(input logic pulse_eoi);
    ack = 1'b1; step(); ack = 1'b0;
    if (pulse_eoi) begin eoi = 1'b1; step(); eoi = 1'b0; end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: valid=%0b vector=%02h expected run to end", irq_valid, irq_vector);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R11 reset", 1'b0, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R11 after release", 1'b0, 8'h00);

    // R1 R2 R3 R4 R6 table (level mode)
    for (int i = 0; i < NV; i++) begin
      ext_pin_n   = TBL[i][23:20];
      ser_rx_flag = TBL[i][19];
      ser_tx_flag = TBL[i][18];
      en_base     = TBL[i][15:10];
      en_ext_hi   = TBL[i][17:16];
      global_en   = TBL[i][9];
      step();
      chk($sformatf("R1/R2/R3/R4 table row %0d", i), TBL[i][8], TBL[i][7:0]);
    end
    ext_pin_n = 4'hF; ser_rx_flag = 0; ser_tx_flag = 0;
    en_base = 6'h3F; en_ext_hi = 2'b11; global_en = 1'b1;
    ext_edge_mode = 4'hF;
    step();
    chk("R5 idle edge mode", 1'b0, 8'h00);

    // R5 edge latch on ext1
    ext_pin_n[1] = 1'b0; step();
    chk("R5 fall latched", 1'b1, exp_vec(2));
    ext_pin_n[1] = 1'b1; step();
    chk("R5 held after release", 1'b1, exp_vec(2));

    // R7 timer0 outranks ext1
    tmr_ovf[0] = 1'b1; step(); tmr_ovf[0] = 1'b0; step();
    chk("R7/R2 timer0 presented", 1'b1, exp_vec(1));
    service(1'b0);
    chk("R9 blocked in service", 1'b0, 8'h00);
    step();
    chk("R9 still blocked", 1'b0, 8'h00);
    eoi = 1'b1; step(); eoi = 1'b0;
    chk("R7/R8/R9 timer0 cleared, ext1 kept", 1'b1, exp_vec(2));
    service(1'b1);
    chk("R8 ext1 edge flag cleared", 1'b0, 8'h00);

    // R10 serial survives ack
    ser_tx_flag = 1'b1; step();
    chk("R10 serial tx", 1'b1, exp_vec(4));
    service(1'b1);
    chk("R10 serial kept after ack", 1'b1, exp_vec(4));
    ser_tx_flag = 1'b0; step();
    chk("R10 serial dropped by software", 1'b0, 8'h00);

    // R9 request arriving during service
    tmr_ovf[2] = 1'b1; step(); tmr_ovf[2] = 1'b0;
    chk("R1 timer2 vector", 1'b1, exp_vec(5));
    service(1'b0);
    tmr_ovf[1] = 1'b1; step(); tmr_ovf[1] = 1'b0;
    chk("R9 new request held", 1'b0, 8'h00);
    eoi = 1'b1; step(); eoi = 1'b0;
    chk("R9 held request after eoi", 1'b1, exp_vec(3));

    // R4 global mask with timer1 pending
    global_en = 1'b0; step();
    chk("R4 global off", 1'b0, 8'h00);
    global_en = 1'b1; step();
    chk("R4 global on", 1'b1, exp_vec(3));
    service(1'b1);
    chk("R7 timer1 cleared", 1'b0, 8'h00);

    // R6 level pulse leaves nothing
    ext_edge_mode[0] = 1'b0;
    ext_pin_n[0] = 1'b0; step();
    chk("R6 level low", 1'b1, exp_vec(0));
    ext_pin_n[0] = 1'b1; step();
    chk("R6 level not latched", 1'b0, 8'h00);

    // R3 latched flag survives disable
    en_ext_hi = 2'b01;
    ext_pin_n[3] = 1'b0; step(); ext_pin_n[3] = 1'b1; step();
    chk("R3 ext3 disabled", 1'b0, 8'h00);
    en_ext_hi = 2'b11; step();
    chk("R3 ext3 enabled later", 1'b1, exp_vec(7));
    service(1'b1);
    chk("R8 ext3 cleared", 1'b0, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule